// File: doc/BRIEF.md
# Quadrature Phase Detector Combiner

This block merges two folded phase readings into one signed phase that covers the full circle. Each reading comes from an analog phase comparator. The comparator's output voltage is linear in the magnitude of the phase difference, from 0° to 180°, so it cannot tell a lead from a lag on its own. One comparator uses an in-phase reference and the other uses a reference shifted by 90°. Each reading arrives as an unsigned ADC code. The block converts both codes to tenths of a degree through per-channel calibration (an offset code and a fixed-point slope). It takes the sign from the quadrature reading. Near the flat ends of the in-phase curve, it takes the magnitude from the quadrature reading instead.

For zero-phase correction, the output is looped back to the input and a calibrate pulse is issued. The phase measured for the next accepted sample is stored and subtracted from every later result, with wrap-around. Samples enter and leave through valid/ready handshakes. The pipeline has a fixed depth, accepts one sample per cycle, and stalls as a whole when the consumer holds off.

Top module: `phq_combiner`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the stored zero offset is 0, so a 0° input reads back as 0.
- R2: Each code converts to tenths of a degree as ((code − offset) × slope + 2^(FRAC−1)) >> FRAC, an arithmetic shift with FRAC = 12 by default. The result is clamped to the range 0..1800.
- R3: The result is negative when the quadrature magnitude mQ exceeds 900 (tenths). It is non-negative when mQ is at most 900.
- R4: When the in-phase magnitude mI lies in 100..1700, the result magnitude equals mI.
- R5: When mI is below 100, the result magnitude is 900 − mQ for a non-negative result and mQ − 900 for a negative one.
- R6: When mI is above 1700, the result magnitude is 900 + mQ for a non-negative result and 2700 − mQ for a negative one.
- R7: The output is the signed phase minus the zero offset, wrapped into −1800..1799 by steps of 3600. A raw phase of +1800 therefore reads as −1800.
- R8: A `cal_pulse`, given alone or in the same cycle as an accepted sample, marks the next accepted sample. That sample's raw phase becomes the new zero offset and it reads as 0. Later samples read relative to that offset.
- R9: A sample accepted on a clock edge appears on `phase_out`, with `out_valid` high, after the third edge that follows, as long as `out_ready` stays high. While `out_valid` is high and `out_ready` is low, the output holds still and `in_ready` is 0.
- R10: With `out_ready` high, back-to-back input samples produce results on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| i_code | input | CODE_W | In-phase comparator ADC code |
| q_code | input | CODE_W | Quadrature comparator ADC code |
| cal_pulse | input | 1 | Capture next sample's phase as zero offset |
| cfg_i_offset | input | CODE_W | In-phase zero-degree code |
| cfg_q_offset | input | CODE_W | Quadrature zero-degree code |
| cfg_i_slope | input | SLOPE_W | In-phase tenths per code, FRAC fraction bits |
| cfg_q_slope | input | SLOPE_W | Quadrature tenths per code, FRAC fraction bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| phase_out | output | 13 | Signed phase, tenths of a degree |

## Verification
Every result is due on the third rising edge after the edge that accepts its sample. Each directed task drives its inputs on a falling edge and counts rising edges from the acceptance edge. It confirms that `out_valid` is still low one edge early and then reads the value on the falling edge after the due edge. The streaming test reads three results on three consecutive falling edges. The stall test keeps `out_ready` low for several cycles past the due edge and checks that both the value and the deasserted `in_ready` hold. It then checks that the result leaves one edge after `out_ready` returns.

// File: rtl/phq_pkg.sv
package phq_pkg;
   // Phase values are signed tenths of a degree
   localparam int PH_W  = 13;
   localparam int MAG_W = 12;
   typedef logic signed [PH_W-1:0] phase_t;
   typedef logic [MAG_W-1:0]       mag_t;

   localparam int HALF_T    = 1800;
   localparam int QUARTER_T = 900;
   localparam int FULL_T    = 3600;
   localparam int LANES     = 2;
endpackage

// File: rtl/phq_conv.sv
module phq_conv
   import phq_pkg::*;
#(
   parameter int CODE_W  = 16,
   parameter int SLOPE_W = 16,
   parameter int FRAC    = 12,
   parameter bit ROUND   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [CODE_W-1:0]  code,
   input  logic [CODE_W-1:0]  offset,
   input  logic [SLOPE_W-1:0] slope,
   output mag_t               mag
);
   localparam int DW = CODE_W + 1;
   localparam int PW = DW + SLOPE_W + 1;
   localparam logic signed [PW-1:0] LIMIT = PW'(HALF_T);

   generate
      if (FRAC < 1 || FRAC >= PW - MAG_W) begin : g_bad_frac
         $error("phq_conv: FRAC out of range");
      end
   endgenerate

   logic signed [DW-1:0] diff_q;
   logic signed [PW-1:0] prod, adj, scaled;
   mag_t                 mag_n;

   // stage A: remove code offset
   always_ff @(posedge clk) begin
      if (!rst_n)  diff_q <= '0;
      else if (en) diff_q <= $signed({1'b0, code}) - $signed({1'b0, offset});
   end

   always_comb prod = PW'(diff_q) * $signed(PW'({1'b0, slope}));

   generate
      if (ROUND) begin : g_round
         localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< (FRAC - 1);
         always_comb adj = prod + HALF_LSB;
      end else begin : g_trunc
         always_comb adj = prod;
      end
   endgenerate

   always_comb begin
      scaled = adj >>> FRAC;
      if (scaled < 0)          mag_n = '0;
      else if (scaled > LIMIT) mag_n = mag_t'(HALF_T);
      else                     mag_n = scaled[MAG_W-1:0];
   end

   // stage B: scaled and clamped magnitude
   always_ff @(posedge clk) begin
      if (!rst_n)  mag <= '0;
      else if (en) mag <= mag_n;
   end
endmodule

// File: rtl/phq_fold.sv
module phq_fold
   import phq_pkg::*;
#(
   parameter int EDGE_T = 100
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  mag_t   mag_i,
   input  mag_t   mag_q,
   output phase_t raw
);
   generate
      if (EDGE_T < 0 || EDGE_T >= QUARTER_T) begin : g_bad_edge
         $error("phq_fold: EDGE_T out of range");
      end
   endgenerate

   localparam phase_t LO_LIM = phase_t'(EDGE_T);
   localparam phase_t HI_LIM = phase_t'(HALF_T - EDGE_T);
   localparam phase_t QTR    = phase_t'(QUARTER_T);
   localparam phase_t TQTR   = phase_t'(3 * QUARTER_T);

   phase_t si, sq, mag_sel, raw_n;
   logic   neg;

   always_comb begin
      si  = $signed({1'b0, mag_i});
      sq  = $signed({1'b0, mag_q});
      neg = sq > QTR;
      if (si < LO_LIM)      mag_sel = neg ? (sq - QTR)  : (QTR - sq);
      else if (si > HI_LIM) mag_sel = neg ? (TQTR - sq) : (QTR + sq);
      else                  mag_sel = si;
      raw_n = neg ? -mag_sel : mag_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  raw <= '0;
      else if (en) raw <= raw_n;
   end
endmodule

// File: rtl/phq_zero.sv
module phq_zero
   import phq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  logic   capture,
   input  phase_t raw,
   output phase_t phase
);
   localparam phase_t HALF = phase_t'(HALF_T);
   localparam phase_t FULL = phase_t'(FULL_T);

   phase_t zoff, delta, wrapped;

   always_comb begin
      delta = capture ? '0 : (raw - zoff);
      if (delta >= HALF)      wrapped = delta - FULL;
      else if (delta < -HALF) wrapped = delta + FULL;
      else                    wrapped = delta;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zoff  <= '0;
         phase <= '0;
      end else if (en) begin
         phase <= wrapped;
         if (capture) zoff <= raw;
      end
   end
endmodule

// File: rtl/phq_combiner.sv
module phq_combiner
   import phq_pkg::*;
#(
   parameter int CODE_W  = 16,
   parameter int SLOPE_W = 16,
   parameter int FRAC    = 12,
   parameter int EDGE_T  = 100,
   parameter bit ROUND   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [CODE_W-1:0]       i_code,
   input  logic [CODE_W-1:0]       q_code,
   input  logic                    cal_pulse,
   input  logic [CODE_W-1:0]       cfg_i_offset,
   input  logic [CODE_W-1:0]       cfg_q_offset,
   input  logic [SLOPE_W-1:0]      cfg_i_slope,
   input  logic [SLOPE_W-1:0]      cfg_q_slope,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic signed [PH_W-1:0]  phase_out
);
   localparam int STAGES = 4;

   generate
      if (CODE_W < 2 || SLOPE_W < 2) begin : g_bad_width
         $error("phq_combiner: widths too small");
      end
   endgenerate

   logic              adv, accept, pend;
   logic [STAGES-1:0] vld, tag;
   logic [CODE_W-1:0]  codes [LANES];
   logic [CODE_W-1:0]  offs  [LANES];
   logic [SLOPE_W-1:0] slps  [LANES];
   mag_t               mags  [LANES];
   phase_t             raw, ph;

   // whole pipeline advances together
   assign adv      = !vld[STAGES-1] || out_ready;
   assign in_ready = adv;
   assign accept   = in_valid && adv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= '0;
         tag  <= '0;
         pend <= 1'b0;
      end else begin
         if (adv) begin
            vld <= {vld[STAGES-2:0], in_valid};
            tag <= {tag[STAGES-2:0], in_valid && (pend || cal_pulse)};
         end
         if (accept)         pend <= 1'b0;
         else if (cal_pulse) pend <= 1'b1;
      end
   end

   assign codes[0] = i_code;       assign codes[1] = q_code;
   assign offs[0]  = cfg_i_offset; assign offs[1]  = cfg_q_offset;
   assign slps[0]  = cfg_i_slope;  assign slps[1]  = cfg_q_slope;

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         phq_conv #(
            .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .FRAC(FRAC), .ROUND(ROUND)
         ) u_conv (
            .clk(clk), .rst_n(rst_n), .en(adv),
            .code(codes[ln]), .offset(offs[ln]), .slope(slps[ln]),
            .mag(mags[ln])
         );
      end
   endgenerate

   phq_fold #(.EDGE_T(EDGE_T)) u_fold (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .mag_i(mags[0]), .mag_q(mags[1]), .raw(raw)
   );

   phq_zero u_zero (
      .clk(clk), .rst_n(rst_n), .en(adv && vld[STAGES-2]),
      .capture(tag[STAGES-2]), .raw(raw), .phase(ph)
   );

   assign out_valid = vld[STAGES-1];
   assign phase_out = ph;
endmodule

// File: rtl/phq_combiner_chk.sv
module phq_combiner_chk #(
   parameter int PW = 13
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic signed [PW-1:0] phase_out
);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(phase_out));

   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (phase_out >= -1800) && (phase_out <= 1799));

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_ready, 4) && $past(out_ready, 3) &&
      $past(out_ready, 2) && $past(out_ready, 1) |-> out_valid);
endmodule

bind phq_combiner phq_combiner_chk #(.PW(phq_pkg::PH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .phase_out(phase_out)
);

// File: tb/phq_combiner_test.sv
module phq_combiner_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, cal_pulse = 1'b0, out_ready = 1'b1;
   logic        in_ready, out_valid;
   logic [15:0] i_code = '0, q_code = '0;
   logic [15:0] cfg_i_offset = '0, cfg_q_offset = '0;
   logic [15:0] cfg_i_slope = 16'd4096, cfg_q_slope = 16'd4096;
   logic signed [12:0] phase_out;

   int checks = 0, errors = 0, zb = 0;

   always #2 clk = ~clk;

   phq_combiner uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .i_code(i_code), .q_code(q_code), .cal_pulse(cal_pulse),
      .cfg_i_offset(cfg_i_offset), .cfg_q_offset(cfg_q_offset),
      .cfg_i_slope(cfg_i_slope), .cfg_q_slope(cfg_q_slope),
      .out_valid(out_valid), .out_ready(out_ready), .phase_out(phase_out)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int wrapm(int v);
      while (v >= 1800) v -= 3600;
      while (v < -1800) v += 3600;
      return v;
   endfunction

   function automatic int absv(int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic int conv(int code, int off, int slope);
      longint p = (longint'(code) - longint'(off)) * longint'(slope) + 2048;
      p = p >>> 12;
      if (p < 0) return 0;
      if (p > 1800) return 1800;
      return int'(p);
   endfunction

   function automatic int combine(int mi, int mq);
      bit neg = mq > 900;
      int m;
      if (mi < 100)       m = neg ? mq - 900 : 900 - mq;
      else if (mi > 1700) m = neg ? 2700 - mq : 900 + mq;
      else                m = mi;
      return neg ? -m : m;
   endfunction

   // one isolated sample, result checked on its due cycle
   task automatic measure(int ic, int qc, bit cal, int exp, string req);
      @(negedge clk);
      in_valid = 1'b1; i_code = 16'(ic); q_code = 16'(qc); cal_pulse = cal;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; cal_pulse = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk({req, " R9 not early"}, int'(out_valid), 0);
      @(posedge clk);
      @(negedge clk);
      chk({req, " R9 due"}, int'(out_valid), 1);
      chk(req, int'(phase_out), exp);
   endtask

   task automatic send_phase(int phi, int k, bit cal, string req);
      int mi = absv(phi);
      int mq = absv(wrapm(phi - 900));
      cfg_i_slope = 16'(4096 / k); cfg_q_slope = 16'(4096 / k);
      if (cal) zb = phi;
      measure(int'(cfg_i_offset) + k * mi, int'(cfg_q_offset) + k * mq,
              cal, wrapm(phi - zb), req);
   endtask

   task automatic t_reset;
      chk("R1 out_valid in reset", int'(out_valid), 0);
      @(negedge clk); rst_n = 1'b1;
      chk("R1 in_ready", int'(in_ready), 1);
      chk("R1 out_valid", int'(out_valid), 0);
      send_phase(0, 1, 1'b0, "R1 zero offset");
   endtask

   task automatic t_mid;
      send_phase(450, 1, 1'b0, "R4 R3 +45");
      send_phase(-450, 1, 1'b0, "R4 R3 -45");
      send_phase(1200, 1, 1'b0, "R4 +120");
      send_phase(-1200, 1, 1'b0, "R4 R3 -120");
      send_phase(100, 1, 1'b0, "R4 low bound");
      send_phase(-1700, 1, 1'b0, "R4 high bound");
   endtask

   task automatic t_edges;
      send_phase(50, 1, 1'b0, "R5 +5");
      send_phase(-50, 1, 1'b0, "R5 R3 -5");
      send_phase(99, 1, 1'b0, "R5 bound");
      send_phase(0, 1, 1'b0, "R5 R3 zero");
      send_phase(1750, 1, 1'b0, "R6 +175");
      send_phase(-1750, 1, 1'b0, "R6 R3 -175");
   endtask

   task automatic t_wrap;
      send_phase(1800, 1, 1'b0, "R7 +180 reads -180");
      send_phase(1799, 1, 1'b0, "R7 +179.9");
   endtask

   task automatic t_conv;
      cfg_i_offset = 16'd1000; cfg_q_offset = 16'd500;
      send_phase(700, 2, 1'b0, "R2 half slope");
      send_phase(-1300, 2, 1'b0, "R2 half slope neg");
      cfg_i_slope = 16'd4096; cfg_q_slope = 16'd2048;
      // q diff 1 at slope 0.5 rounds to 1; i at offset gives 0
      measure(1000, 501, 1'b0, combine(conv(1000, 1000, 4096), conv(501, 500, 2048)),
              "R2 rounding");
      cfg_q_slope = 16'd4096;
      measure(60000, 550, 1'b0, combine(conv(60000, 1000, 4096), 50), "R2 clamp high");
      measure(10, 1300, 1'b0, combine(0, 800), "R2 clamp low");
      cfg_i_offset = '0; cfg_q_offset = '0;
   endtask

   task automatic t_cal;
      send_phase(300, 1, 1'b1, "R8 captured reads zero");
      send_phase(500, 1, 1'b0, "R8 relative");
      send_phase(-1700, 1, 1'b0, "R8 R7 wrap up");
      @(negedge clk); cal_pulse = 1'b1;
      @(negedge clk); cal_pulse = 1'b0;
      zb = -200;
      measure(200, 1100, 1'b0, 0, "R8 pending pulse");
      send_phase(1700, 1, 1'b0, "R8 R7 wrap down");
      send_phase(0, 1, 1'b1, "R8 restore");
   endtask

   task automatic t_stream;
      int ph[3] = '{300, -600, 1500};
      for (int n = 0; n < 3; n++) begin
         @(negedge clk);
         in_valid = 1'b1;
         i_code = 16'(absv(ph[n])); q_code = 16'(absv(wrapm(ph[n] - 900)));
         @(posedge clk);
      end
      @(negedge clk); in_valid = 1'b0;
      for (int n = 0; n < 3; n++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R10 back-to-back valid", int'(out_valid), 1);
         chk("R10 back-to-back value", int'(phase_out), ph[n]);
      end
      @(posedge clk); @(negedge clk);
      chk("R10 drained", int'(out_valid), 0);
   endtask

   task automatic t_stall;
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; i_code = 16'd800; q_code = 16'd1700;
      @(posedge clk);
      @(negedge clk); in_valid = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R9 stalled valid", int'(out_valid), 1);
      chk("R9 stalled in_ready", int'(in_ready), 0);
      chk("R9 stalled value", int'(phase_out), -800);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 held value", int'(phase_out), -800);
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R9 released", int'(out_valid), 0);
   endtask

   initial begin
      #(4 * 100000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_mid();
      t_edges();
      t_wrap();
      t_conv();
      t_cal();
      t_stream();
      t_stall();
      repeat (2) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule